// File: doc/BRIEF.md
# Decimation Ratio Output-Word Timer

This block keeps an 11-bit decimation ratio split across two byte-wide registers on a small register bus. It counts modulator clock cycles and raises a one-cycle output-word strobe at the end of every conversion period. A period lasts (ratio field + 1) × 128 cycles.

Register writes are accepted only while the block is idle. Ratio fields below 19 are counted as 19. When fast-filter mode is selected, the field must have its three low bits all set; a start with any other field is refused and latches an error flag.

A controller programs the ratio, selects the filter mode and pulses `start`. The timer then repeats periods until `stop` is pulsed. The ratio registers always read back the stored value, never the clamped one.

Top module: `dec_word_timer`

## Requirements
- R1: After reset, the low register (address 0x9A) reads 0xFF, the high register (address 0x9B) reads 0x07, `busy` is 0, `cfg_err` is 0 and `word_strobe` is 0.
- R2: The high register stores only bits 2:0, which are ratio field bits 10:8. Its bits 7:3 always read 0, and writes to them are ignored. The low register holds field bits 7:0. Any other address reads 0.
- R3: For a field F of 19 or more, a period is (F+1)·128 cycles. The first strobe is seen (F+1)·128 edges after the edge that samples an accepted `start`, and further strobes follow every (F+1)·128 edges.
- R4: A field below 19 produces periods of 20·128 = 2560 cycles. Read-back still returns the raw stored value.
- R5: A register write while `busy` is 1 changes neither register's read-back value nor the running period.
- R6: With `fast_mode` = 1 and field bits 2:0 not equal to 3'b111, a `start` is refused: `busy` stays 0, no strobe occurs, and `cfg_err` becomes 1 after that edge.
- R7: With `fast_mode` = 1 and field bits 2:0 equal to 3'b111, a `start` is accepted and periods follow R3.
- R8: `stop` takes priority over `start`. After the edge that samples `stop`, `busy` is 0 and no strobe follows. A later `start` begins a full new period.
- R9: `cfg_err` stays 1 until a register write is accepted while idle. That write clears it after its edge.
- R10: `busy` is 1 from the edge that samples an accepted `start` until a stop. `word_strobe` is high for exactly one cycle per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| start | input | 1 | Start request, sampled while idle |
| stop | input | 1 | Stop request, returns to idle |
| fast_mode | input | 1 | Fast-filter mode select |
| word_strobe | output | 1 | One-cycle pulse at the end of each period |
| busy | output | 1 | Conversion running |
| cfg_err | output | 1 | Sticky fast-mode alignment error |

## Verification
Period length is measured for fields below, at and just above the minimum of 19, which separates clamping from plain counting. Random fields in the range 0 to 40, under random filter modes, mix accepted and refused starts; this exposes off-by-one errors and wrong alignment decoding. Directed writes during a run and stops in the middle of a period show whether the register lock and the counter clear work. Fast mode is tried with both aligned and misaligned fields, which tells a refused start apart from a late one.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
    localparam int unsigned RATIO_W   = 11;
    localparam int unsigned PRE_LOG2  = 7;
    localparam int unsigned MIN_FIELD = 19;
    localparam int unsigned ALIGN_W   = 3;
    localparam int unsigned CNT_W     = RATIO_W + PRE_LOG2 + 1;
    localparam logic [7:0]  ADDR_LO   = 8'h9A;
    localparam logic [7:0]  ADDR_HI   = 8'h9B;
    localparam logic [RATIO_W-1:0] FIELD_RST = {RATIO_W{1'b1}};

    typedef enum logic {ST_IDLE, ST_RUN} run_state_t;

    typedef struct packed {
        logic [RATIO_W-9:0] hi;
        logic [7:0]         lo;
    } ratio_regs_t;

    function automatic logic [RATIO_W-1:0] clamp_field(input logic [RATIO_W-1:0] f);
        return (f < RATIO_W'(MIN_FIELD)) ? RATIO_W'(MIN_FIELD) : f;
    endfunction

    function automatic logic [CNT_W-1:0] period_len(input logic [RATIO_W-1:0] f);
        logic [CNT_W-1:0] r;
        r = CNT_W'(clamp_field(f)) + CNT_W'(1);
        return r << PRE_LOG2;
    endfunction

    function automatic logic field_aligned(input logic [RATIO_W-1:0] f);
        return &f[ALIGN_W-1:0];
    endfunction
endpackage

// File: rtl/dwt_regs.sv
module dwt_regs
    import dwt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    input  logic               reg_we,
    input  logic               busy,
    output logic [7:0]         reg_rdata,
    output logic [RATIO_W-1:0] field,
    output logic               cfg_write
);
    localparam int unsigned HI_W = RATIO_W - 8;

    ratio_regs_t regs_q;
    logic        wr_ok;

    assign wr_ok     = reg_we && !busy;
    assign cfg_write = wr_ok && (reg_addr == ADDR_LO || reg_addr == ADDR_HI);
    assign field     = regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= FIELD_RST;
        end else if (wr_ok) begin
            if (reg_addr == ADDR_LO) regs_q.lo <= reg_wdata;
            if (reg_addr == ADDR_HI) regs_q.hi <= reg_wdata[HI_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == ADDR_LO) reg_rdata = regs_q.lo;
        else if (reg_addr == ADDR_HI) reg_rdata = {{(8-HI_W){1'b0}}, regs_q.hi};
    end
endmodule

// File: rtl/dwt_ctrl.sv
module dwt_ctrl
    import dwt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    input  logic fast_mode,
    input  logic aligned,
    input  logic cfg_write,
    output logic load,
    output logic busy,
    output logic cfg_err
);
    run_state_t state_q;
    logic       req, refuse;

    assign req    = (state_q == ST_IDLE) && start && !stop;
    assign refuse = req && fast_mode && !aligned;
    assign load   = req && !refuse;
    assign busy   = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_err <= 1'b0;
        end else begin
            if (stop)      state_q <= ST_IDLE;
            else if (load) state_q <= ST_RUN;
            if (refuse)         cfg_err <= 1'b1;
            else if (cfg_write) cfg_err <= 1'b0;
        end
    end
endmodule

// File: rtl/dwt_counter.sv
module dwt_counter
    import dwt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               stop,
    input  logic               busy,
    input  logic [RATIO_W-1:0] field,
    output logic               word_strobe
);
    logic [CNT_W-1:0] cnt_q, reload;

    assign reload = period_len(field) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || stop) begin
            cnt_q       <= '0;
            word_strobe <= 1'b0;
        end else if (load) begin
            cnt_q       <= reload;
            word_strobe <= 1'b0;
        end else if (busy && cnt_q == '0) begin
            cnt_q       <= reload;
            word_strobe <= 1'b1;
        end else begin
            if (busy) cnt_q <= cnt_q - CNT_W'(1);
            word_strobe <= 1'b0;
        end
    end
endmodule

// File: rtl/dec_word_timer.sv
module dec_word_timer
    import dwt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    input  logic       reg_we,
    output logic [7:0] reg_rdata,
    input  logic       start,
    input  logic       stop,
    input  logic       fast_mode,
    output logic       word_strobe,
    output logic       busy,
    output logic       cfg_err
);
    logic [RATIO_W-1:0] field;
    logic               cfg_write, load;

    dwt_regs u_regs (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .busy(busy), .reg_rdata(reg_rdata),
        .field(field), .cfg_write(cfg_write)
    );

    dwt_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .fast_mode(fast_mode),
        .aligned(field_aligned(field)), .cfg_write(cfg_write),
        .load(load), .busy(busy), .cfg_err(cfg_err)
    );

    dwt_counter u_cnt (
        .clk(clk), .rst(rst), .load(load), .stop(stop), .busy(busy),
        .field(field), .word_strobe(word_strobe)
    );
endmodule

// File: rtl/dwt_checker.sv
module dwt_checker
    import dwt_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [7:0]         reg_addr,
    input logic               reg_we,
    input logic [7:0]         reg_rdata,
    input logic               start,
    input logic               stop,
    input logic               fast_mode,
    input logic               word_strobe,
    input logic               busy,
    input logic               cfg_err,
    input logic [RATIO_W-1:0] field
);
    assert_hi_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_HI) |-> (reg_rdata[7:3] == 5'b0));

    assert_locked_while_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_we) |=> $stable(field));

    assert_refuse_misaligned_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !stop && fast_mode && !field_aligned(field)) |=> (!busy && cfg_err));

    assert_stop_idles_R8: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!busy && !word_strobe));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && !reg_we) |=> cfg_err);

    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (rst)
        word_strobe |=> !word_strobe);

    assert_strobe_needs_busy_R10: assert property (@(posedge clk) disable iff (rst)
        word_strobe |-> $past(busy));
endmodule

bind dec_word_timer dwt_checker u_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .start(start), .stop(stop), .fast_mode(fast_mode), .word_strobe(word_strobe),
    .busy(busy), .cfg_err(cfg_err), .field(field)
);

// File: tb/dec_word_timer_test.sv
module dec_word_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
    logic       reg_we = 1'b0, start = 1'b0, stop = 1'b0, fast_mode = 1'b0;
    logic [7:0] reg_rdata;
    logic       word_strobe, busy, cfg_err;

    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dec_word_timer uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .start(start), .stop(stop),
        .fast_mode(fast_mode), .word_strobe(word_strobe), .busy(busy), .cfg_err(cfg_err)
    );

    function automatic int exp_period(input int f);
        return ((f < 19) ? 20 : f + 1) * 128;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic set_field(input int f);
        wr(8'h9A, 8'(f & 8'hFF));
        wr(8'h9B, 8'((f >> 8) | 8'hF8));
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic wait_strobe(output int n);
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!word_strobe && n < 20000);
    endtask

    task automatic run_check(input string req, input int f);
        int n, w;
        pulse_start();
        check({req, " busy after start"}, busy, 1);
        wait_strobe(n);
        check({req, " first period"}, n, exp_period(f));
        @(negedge clk);
        check("R10 strobe one cycle", word_strobe, 0);
        wait_strobe(w);
        check({req, " second period"}, w + 1, exp_period(f));
        do_stop();
        check("R8 idle after stop", busy, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v, n;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(8'h9A, v); check("R1 low reset", v, 8'hFF);
        rd(8'h9B, v); check("R1 high reset", v, 8'h07);
        check("R1 busy reset", busy, 0);
        check("R1 err reset", cfg_err, 0);
        check("R1 strobe reset", word_strobe, 0);

        wr(8'h9B, 8'hFD);
        rd(8'h9B, v); check("R2 upper bits dropped", v, 8'h05);
        rd(8'h55, v); check("R2 unused address", v, 0);

        set_field(0);
        rd(8'h9A, v); check("R4 raw read low", v, 0);
        run_check("R4 clamp 0", 0);
        set_field(19); run_check("R3 field 19", 19);
        set_field(20); run_check("R3 field 20", 20);

        set_field(25);
        pulse_start();
        repeat (50) @(negedge clk);
        wr(8'h9A, 8'h00);
        rd(8'h9A, v); check("R5 locked read", v, 25);
        wait_strobe(n);
        check("R5 period unchanged", n + 52, exp_period(25));
        repeat (1000) @(negedge clk);
        do_stop();
        check("R8 busy low", busy, 0);
        n = 0;
        repeat (3500) begin @(negedge clk); if (word_strobe) n++; end
        check("R8 no strobe after stop", n, 0);

        fast_mode = 1'b1;
        set_field(20);
        pulse_start();
        check("R6 refused busy", busy, 0);
        check("R6 err set", cfg_err, 1);
        n = 0;
        repeat (3000) begin @(negedge clk); if (word_strobe) n++; end
        check("R6 no strobe", n, 0);
        fast_mode = 1'b0;
        pulse_start();
        check("R9 err sticky while running", cfg_err, 1);
        do_stop();
        check("R9 err kept after stop", cfg_err, 1);
        wr(8'h9A, 8'd23);
        check("R9 err cleared by write", cfg_err, 0);
        fast_mode = 1'b1;
        run_check("R7 fast aligned", 23);
        fast_mode = 1'b0;

        for (int i = 0; i < 6; i++) begin
            int f;
            f = $urandom_range(0, 40);
            fast_mode = 1'($urandom_range(0, 1));
            set_field(f);
            if (fast_mode && (f & 7) != 7) begin
                pulse_start();
                check("R6 random refused", busy, 0);
                check("R6 random err", cfg_err, 1);
                wr(8'h9A, 8'(f));
            end else begin
                run_check("R3 random", f);
            end
            rd(8'h9A, v); check("R4 random raw read", v, f);
        end
        fast_mode = 1'b0;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule